// File: doc/BRIEF.md
# APB Completer Register Bank

This block sits on the completer side of an APB bus and holds four 32-bit registers. It only watches the select, enable, address, direction and write-data inputs. It drives only the read-data and ready outputs, and it never drives the enable strobe. In the first cycle of a transfer (select high, enable low) it decodes the address and registers the result, and it changes no state.

During the access phase the bank can stretch the transfer. A parameter sets a fixed number of wait cycles, from 0 to 3, and ready is held low for that many cycles. A write takes effect, and read data is valid, only in the cycle where select, enable and ready are all high. This keeps a write from being taken early or applied more than once while the bank is holding off its own transfer. The wait counter returns to zero whenever select or enable is low, so every transfer waits the same number of cycles, including back-to-back transfers.

Addresses are byte addresses and registers sit on word boundaries, so the register index is address bits [3:2]. Any address whose word index is 4 or higher reads as zero, and writes to it are dropped.

Top module: `apb_regbank`

## Requirements
- R1: A synchronous active-low reset clears all four registers to zero, so a read of any register after reset returns 0.
- R2: In a setup cycle (psel=1, penable=0) the bank keeps pready at 0, prdata at 0 and every register unchanged.
- R3: With WAIT_CYCLES=N, pready is 0 for the first N access cycles (psel=1, penable=1) and 1 in access cycle N+1.
- R4: The wait count restarts for every transfer, so back-to-back transfers, with no idle cycle between them, each see exactly N wait cycles.
- R5: A write with word index paddr[7:2] below 4 stores pwdata into register paddr[3:2], and only in the cycle where psel, penable and pready are all 1. A later read of that register returns the value.
- R6: prdata carries the addressed register's value in the completion cycle of a read (psel, penable and pready all 1, pwrite=0). In every other cycle, wait cycles included, prdata is 0.
- R7: An address with word index 4 or higher (for example 0x10 or 0xFC) reads as 0, and a write to it leaves all four registers unchanged.
- R8: While psel is 0, pready and prdata stay 0 and the registers do not change, whatever penable, pwrite, paddr and pwdata do.
- R9: A register keeps its value across idle cycles and across transfers to other registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| psel | input | 1 | Completer select |
| penable | input | 1 | Access-phase strobe, sampled only |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (8) | Byte address |
| pwdata | input | DATA_W (32) | Write data |
| prdata | output | DATA_W (32) | Read data, non-zero only at read completion |
| pready | output | 1 | Completion / wait-state control |

## Verification
The bench drives three banks built with zero, one and two wait states. It counts the low-ready access cycles of every transfer, so a counter that is not cleared between back-to-back transfers shows up as a wrong wait count on the second transfer. Read data is checked to be zero in setup and wait cycles, which catches a design that presents data as soon as enable rises. Writes to 0x10 and 0xFC, followed by read-back of all four registers, expose decode that drops the upper address bits and aliases onto register 0. Enable and write toggling with select low checks that the bank never acts on enable by itself.

// File: rtl/regbank_pkg.sv
// Package: shared constants and the bus-phase classification used by the
// register bank. Assumes byte addressing with word-aligned registers.
package regbank_pkg;

    // Number of byte-offset bits below the word index.
    localparam int unsigned BYTE_LSB = 2;

    // Phase of the bus as seen by the completer in the current cycle.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2
    } bus_phase_e;

    // Classify the current cycle from select and enable.
    function automatic bus_phase_e classify(input logic sel, input logic en);
        if (!sel)     return PH_IDLE;
        else if (!en) return PH_SETUP;
        else          return PH_ACCESS;
    endfunction

endpackage

// File: rtl/apb_wait_gen.sv
// Module: apb_wait_gen
// Holds ready low for WAIT_CYCLES access cycles, then raises it. The count is
// cleared in every non-access cycle. Assumes WAIT_CYCLES is in 0..3 and that
// the manager keeps the access phase until ready is seen.
module apb_wait_gen #(
    parameter int unsigned WAIT_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_access,
    output logic ready
);
    localparam int unsigned CNT_W = (WAIT_CYCLES < 1) ? 1 : $clog2(WAIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WAIT_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Count access cycles up to the limit; restart outside the access phase.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (!in_access)  cnt_q <= '0;
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    // Ready only once the configured number of wait cycles has elapsed.
    always_comb ready = in_access && (cnt_q == LIMIT);

    // R3
    wait_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);

    // R4
    wait_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_access |=> (cnt_q == '0));

endmodule

// File: rtl/apb_addr_decode.sv
// Module: apb_addr_decode
// Decodes the byte address in the setup cycle and holds the register index and
// an in-range flag for the access phase. Assumes paddr is stable for the whole
// transfer.
module apb_addr_decode
    import regbank_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned NUM_REGS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_setup,
    input  logic [ADDR_W-1:0] addr,
    output logic [$clog2(NUM_REGS)-1:0] idx,
    output logic              hit
);
    localparam int unsigned IDX_W  = $clog2(NUM_REGS);
    localparam int unsigned WORD_W = ADDR_W - BYTE_LSB;

    logic [WORD_W-1:0] word;
    logic [IDX_W-1:0]  idx_q;
    logic              hit_q;

    // Word index of the current address.
    always_comb word = addr[ADDR_W-1:BYTE_LSB];

    // Capture the decode in the setup cycle; hold it through the access phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            hit_q <= 1'b0;
        end else if (in_setup) begin
            idx_q <= word[IDX_W-1:0];
            hit_q <= (word < WORD_W'(NUM_REGS));
        end
    end

    // Present the held decode.
    always_comb begin
        idx = idx_q;
        hit = hit_q;
    end

    // R7
    decode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_setup |=> $stable(hit_q) && $stable(idx_q));

endmodule

// File: rtl/apb_reg_store.sv
// Module: apb_reg_store
// The register array: one write port enabled only at commit, one
// combinational read port. Assumes the caller qualifies the write enable.
module apb_reg_store #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_REGS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [$clog2(NUM_REGS)-1:0] idx,
    input  logic [DATA_W-1:0]           wdata,
    output logic [DATA_W-1:0]           rdata
);
    logic [DATA_W-1:0] regs_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // Load one register when the commit targets it; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)                       regs_q[g] <= '0;
            else if (wr_en && (idx == g))     regs_q[g] <= wdata;
        end

        // R9
        reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (idx == g)) |=> $stable(regs_q[g]));
    end

    // Select the addressed register for reading.
    always_comb rdata = regs_q[idx];

    // R5
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (regs_q[$past(idx)] == $past(wdata)));

endmodule

// File: rtl/apb_regbank.sv
// Module: apb_regbank (top)
// Completer-side register bank with four registers and fixed wait states.
// Samples but never drives the enable strobe; commits and returns read data
// only when select, enable and ready are all high. Assumes a well-behaved
// manager (address and controls stable through each transfer).
module apb_regbank
    import regbank_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned NUM_REGS    = 4,
    parameter int unsigned WAIT_CYCLES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready
);
    localparam int unsigned IDX_W = $clog2(NUM_REGS);

    bus_phase_e        phase;
    logic              in_setup;
    logic              in_access;
    logic              done;
    logic [IDX_W-1:0]  idx;
    logic              hit;
    logic              wr_commit;
    logic [DATA_W-1:0] rd_word;

    // Work out which phase the bus is in this cycle.
    always_comb begin
        phase     = classify(psel, penable);
        in_setup  = (phase == PH_SETUP);
        in_access = (phase == PH_ACCESS);
    end

    apb_wait_gen #(.WAIT_CYCLES(WAIT_CYCLES)) u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_access (in_access),
        .ready     (pready)
    );

    apb_addr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_setup (in_setup),
        .addr     (paddr),
        .idx      (idx),
        .hit      (hit)
    );

    // Completion and write commit: select, enable and ready together.
    always_comb begin
        done      = psel && penable && pready;
        wr_commit = done && pwrite && hit;
    end

    apb_reg_store #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_commit),
        .idx   (idx),
        .wdata (pwdata),
        .rdata (rd_word)
    );

    // Drive read data only at read completion of an in-range register.
    always_comb prdata = (done && !pwrite && hit) ? rd_word : '0;

    // R2
    setup_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !penable) |-> !pready && (prdata == '0));

    // R3
    first_access_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (WAIT_CYCLES > 0 && psel && penable && !$past(penable)) |-> !pready);

    // R6
    rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(psel && penable && pready) |-> (prdata == '0));

    // R8
    unselected_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !psel |-> !pready);

endmodule

// File: tb/apb_regbank_bench.sv
// Bench: three banks with 0, 1 and 2 wait states, each driven by its own
// modelled manager; a behavioural register model gives the expected values.
module apb_regbank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic        psel    [NB];
    logic        penable [NB];
    logic        pwrite  [NB];
    logic [7:0]  paddr   [NB];
    logic [31:0] pwdata  [NB];
    logic [31:0] prdata  [NB];
    logic        pready  [NB];

    logic [31:0] model [NB][4];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    for (genvar g = 0; g < NB; g++) begin : g_dut
        apb_regbank #(.WAIT_CYCLES(g)) u_apb_regbank (
            .clk     (clk),
            .rst_n   (rst_n),
            .psel    (psel[g]),
            .penable (penable[g]),
            .pwrite  (pwrite[g]),
            .paddr   (paddr[g]),
            .pwdata  (pwdata[g]),
            .prdata  (prdata[g]),
            .pready  (pready[g])
        );
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Every clock: an unselected bank must keep ready and read data low (R8).
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            for (int k = 0; k < NB; k++) begin
                if (!psel[k]) begin
                    chk(pready[k] == 1'b0, "R8 pready", 32'(pready[k]), 0);
                    chk(prdata[k] == 32'd0, "R8 prdata", prdata[k], 0);
                end
            end
        end
    end

    // One transfer on bank k; returns just after the completion cycle is seen.
    task automatic xfer(input int k, input bit wr, input logic [7:0] a, input logic [31:0] d, input string req);
        int waits;
        bit inr;
        logic [31:0] exp;
        @(negedge clk);
        psel[k] = 1'b1; penable[k] = 1'b0; paddr[k] = a; pwrite[k] = wr; pwdata[k] = d;
        #1;
        chk(pready[k] == 1'b0, "R2 setup pready", 32'(pready[k]), 0);
        chk(prdata[k] == 32'd0, "R2 setup prdata", prdata[k], 0);
        @(negedge clk);
        penable[k] = 1'b1;
        #1;
        waits = 0;
        while (!pready[k] && waits < 8) begin
            chk(prdata[k] == 32'd0, "R6 wait prdata", prdata[k], 0);
            waits++;
            @(negedge clk);
            #1;
        end
        chk(waits == k, "R3 R4 wait count", 32'(waits), 32'(k));
        inr = (a[7:4] == 4'd0);
        if (!wr) begin
            exp = inr ? model[k][a[3:2]] : 32'd0;
            chk(prdata[k] == exp, req, prdata[k], exp);
        end else begin
            chk(prdata[k] == 32'd0, "R6 write prdata", prdata[k], 0);
            if (inr) model[k][a[3:2]] = d;
        end
    endtask

    task automatic idle(input int k, input int n);
        @(negedge clk);
        psel[k] = 1'b0; penable[k] = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic read_all(input int k, input string req);
        for (int i = 0; i < 4; i++) xfer(k, 1'b0, 8'(i * 4), 32'd0, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < NB; k++)
            for (int i = 0; i < 4; i++) model[k][i] = 32'd0;
    endtask

    initial begin
        for (int k = 0; k < NB; k++) begin
            psel[k] = 0; penable[k] = 0; pwrite[k] = 0; paddr[k] = 0; pwdata[k] = 0;
            for (int i = 0; i < 4; i++) model[k][i] = 32'd0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < NB; k++) begin
            // R1: all registers read zero after reset
            read_all(k, "R1 reset read");
            idle(k, 2);
            // R5: back-to-back writes to every register, then read back (R4 spacing)
            for (int i = 0; i < 4; i++)
                xfer(k, 1'b1, 8'(i * 4), 32'hA500_0000 | 32'(k << 8) | 32'(i), "R5 write");
            read_all(k, "R5 readback");
            idle(k, 3);
            // R9: overwrite one register, others must hold
            xfer(k, 1'b1, 8'h08, 32'h1234_5678 + 32'(k), "R9 write");
            idle(k, 2);
            read_all(k, "R9 hold");
            // R7: out-of-range writes dropped, reads zero
            xfer(k, 1'b1, 8'h10, 32'hDEAD_BEEF, "R7 write");
            xfer(k, 1'b1, 8'hFC, 32'hFEED_F00D, "R7 write");
            xfer(k, 1'b0, 8'h10, 32'd0, "R7 read 0x10");
            xfer(k, 1'b0, 8'hFC, 32'd0, "R7 read 0xFC");
            read_all(k, "R7 regs unchanged");
            // R8: enable and write toggling without select
            @(negedge clk);
            psel[k] = 0; penable[k] = 1; pwrite[k] = 1; paddr[k] = 8'h04; pwdata[k] = 32'hBAD0_BAD0;
            repeat (3) @(negedge clk);
            penable[k] = 0;
            read_all(k, "R8 regs unchanged");
            idle(k, 2);
        end

        // R1: reset in the middle of use clears everything
        do_reset();
        for (int k = 0; k < NB; k++) begin
            read_all(k, "R1 mid reset read");
            idle(k, 1);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule